// File: doc/BRIEF.md
# Configurable External Interrupt Input Conditioner

This block prepares a set of external interrupt request pins for a downstream priority encoder. Each pin first passes through a two-flop synchronizer. It is then inverted or passed through according to a per-line polarity bit. The line's mode bit decides how the result becomes a pending bit. In level mode the pending bit tracks the active condition. In edge mode the pending bit is set by a transition into the active state and stays set until software clears it.

A small register port writes three control vectors: polarity, mode and enable. It reads them back, together with the pending vector, and clears pending bits by writing ones to them. The block drives the pending vector directly. It also drives a single combined request, which is the OR of the pending bits whose enable bit is set.

In edge mode the previous active sample is held at zero while a line sits in level mode. Moving a line from level to edge mode while its condition is active therefore posts an interrupt. In edge mode, changing the polarity so that the line becomes active also posts an interrupt.

Top module: `irq_input_conditioner`

## Requirements
- R1: After reset the polarity, mode and enable vectors read 0, `pending` is 0, `irq_req` is 0 and `rd_data` is 0.
- R2: With polarity bit 0 and mode bit 0, a line's `pending` bit is 1 while its pin is low and 0 while it is high. It follows the pin 3 clock edges after the pin changes.
- R3: With polarity bit 1 and mode bit 0, a line's `pending` bit is 1 while its pin is high. It follows a change of the polarity bit 2 edges after the write.
- R4: With mode bit 1 and polarity bit 0, a high-to-low pin transition sets the `pending` bit 3 edges later. The bit stays set after the pin returns high.
- R5: With mode bit 1 and polarity bit 1, a low-to-high transition sets the `pending` bit. A high-to-low transition does not clear it.
- R6: A write to address 3 clears each edge-mode `pending` bit whose data bit is 1, at the write's clock edge. Data bits of 0 leave the pending bits unchanged.
- R7: A clear write to a level-mode line whose condition is still active leaves its `pending` bit at 1.
- R8: When a new edge is detected in the same cycle as a clear write to that line, the `pending` bit stays 1.
- R9: Writing a line's mode bit from 0 to 1 while its condition is active posts that line's `pending` bit. The bit survives a clear write issued in the next cycle.
- R10: `irq_req` is 1 exactly when some `pending` bit with a set enable bit was 1 one cycle earlier. Pending lines without enable do not raise it.
- R11: Addresses 0, 1, 2 and 3 read the polarity, mode, enable and pending vectors. `rd_data` is valid one cycle after `rd_en` and holds its value while `rd_en` is low.
- R12: Lines are independent: stimulus on one pin or control bit never changes another line's `pending` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N | Asynchronous interrupt request pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 polarity, 1 mode, 2 enable, 3 clear pending) |
| wr_data | input | N | Write data, one bit per line |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address (0 polarity, 1 mode, 2 enable, 3 pending) |
| rd_data | output | N | Registered read data |
| pending | output | N | Registered per-line pending status |
| irq_req | output | 1 | Registered combined request |

## Verification
A wrong synchronizer or polarity state shows on `pending` 3 edges after a pin change, as a bit that is set or clear when it should not be. A lost or stale previous-sample register shows either as a missing pending bit after an edge, or as a mode switch that posts nothing. A faulty clear path shows on the cycle right after the clear write. It appears as a bit that survives a clear, as a bit that drops despite a simultaneous edge, or as a neighbouring line that gets cleared. A bad enable vector shows on `irq_req` one edge after `pending` and can also be read back on the register port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_POL  = 2'd0,
    REG_MODE = 2'd1,
    REG_EN   = 2'd2,
    REG_STAT = 2'd3
  } irqc_reg_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int          W       = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= {W{RST_VAL}};
      sync_out <= {W{RST_VAL}};
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic pol,
  input  logic edge_mode,
  input  logic clr,
  output logic act,
  output logic hit,
  output logic status
);
  logic prev_act;

  // polarity 1 = active high, 0 = active low
  assign act = pol ? smp : ~smp;
  // previous sample is held at 0 outside edge mode, so entering edge
  // mode while active yields a transition
  assign hit = edge_mode & act & ~prev_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act <= 1'b0;
      status   <= 1'b0;
    end else begin
      prev_act <= edge_mode ? act : 1'b0;
      if (edge_mode) status <= hit | (status & ~clr);
      else           status <= act;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [N-1:0]      stat,
  output logic [N-1:0]      ctl_pol,
  output logic [N-1:0]      ctl_mode,
  output logic [N-1:0]      ctl_en,
  output logic [N-1:0]      stat_clr,
  output logic [N-1:0]      rd_data
);
  assign stat_clr = (wr_en && wr_addr == REG_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_pol  <= '0;
      ctl_mode <= '0;
      ctl_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_POL:  ctl_pol  <= wr_data;
        REG_MODE: ctl_mode <= wr_data;
        REG_EN:   ctl_en   <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        REG_POL:  rd_data <= ctl_pol;
        REG_MODE: rd_data <= ctl_mode;
        REG_EN:   rd_data <= ctl_en;
        default:  rd_data <= stat;
      endcase
    end
  end
endmodule

// File: rtl/irq_input_conditioner.sv
module irq_input_conditioner
  import irqc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_in,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  output logic [N-1:0]      pending,
  output logic              irq_req
);
  logic [N-1:0] pin_sync;
  logic [N-1:0] ctl_pol, ctl_mode, ctl_en, stat_clr;
  logic [N-1:0] line_act, line_hit, stat;

  irqc_sync #(.W(N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  irqc_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .stat(stat),
    .ctl_pol(ctl_pol), .ctl_mode(ctl_mode), .ctl_en(ctl_en),
    .stat_clr(stat_clr), .rd_data(rd_data)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    irqc_line u_line (
      .clk(clk), .rst(rst),
      .smp(pin_sync[i]), .pol(ctl_pol[i]), .edge_mode(ctl_mode[i]),
      .clr(stat_clr[i]),
      .act(line_act[i]), .hit(line_hit[i]), .status(stat[i])
    );
  end

  assign pending = stat;

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= |(stat & ctl_en);
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         rd_en,
  input logic [N-1:0] rd_data,
  input logic [N-1:0] pending,
  input logic         irq_req,
  input logic [N-1:0] ctl_mode,
  input logic [N-1:0] ctl_en,
  input logic [N-1:0] line_act,
  input logic [N-1:0] line_hit,
  input logic [N-1:0] stat_clr
);
  // R1: reset empties pending and request
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (pending == '0 && irq_req == 1'b0));

  // R2: level lines mirror the previous active sample
  a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pending ^ $past(line_act)) & ~$past(ctl_mode)) == '0));

  // R4: edge pending bits hold without a clear
  a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pending & ctl_mode & ~stat_clr) & ~pending) == '0));

  // R8: a detected edge always leaves the bit set
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (line_hit != '0) |=> (($past(line_hit) & ~pending) == '0));

  // R10: combined request from enabled pending bits
  a_r10_req_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == |($past(pending) & $past(ctl_en))));

  // R11: read data holds without a read strobe
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind irq_input_conditioner irqc_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
  .pending(pending), .irq_req(irq_req), .ctl_mode(ctl_mode),
  .ctl_en(ctl_en), .line_act(line_act), .line_hit(line_hit),
  .stat_clr(stat_clr)
);

// File: tb/sim_irq_input_conditioner.sv
`timescale 1ns/1ps
module sim_irq_input_conditioner;
  localparam int N = 4;

  typedef struct {
    string      tag;
    int         kind;   // 0 pending, 1 irq_req, 2 rd_data
    logic [7:0] val;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_in = '1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data, pending;
  logic         irq_req;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  irq_input_conditioner #(.N(N)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pending(pending), .irq_req(irq_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag, input int kind, input logic [7:0] val);
    exp_t e;
    e.tag = tag; e.kind = kind; e.val = val;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [N-1:0] expv);
    rd_en = 1'b1; rd_addr = a;
    step(1);
    rd_en = 1'b0;
    push(tag, 2, 8'(expv));
  endtask

  // monitor: compares queued expectations just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        case (e.kind)
          0:       act = 8'(pending);
          1:       act = 8'(irq_req);
          default: act = 8'(rd_data);
        endcase
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s actual %0h expected %0h", e.tag, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(3);
    push("R1 pending", 0, 8'h0);
    push("R1 irq_req", 1, 8'h0);
    push("R1 rd_data", 2, 8'h0);
    rd_chk("R1 pol", 2'd0, 4'h0);
    rd_chk("R1 mode", 2'd1, 4'h0);
    rd_chk("R1 en", 2'd2, 4'h0);

    // R2 level negative on line 0
    pin_in[0] = 1'b0; step(3);
    push("R2 low asserts", 0, 8'h1);
    pin_in[0] = 1'b1; step(3);
    push("R2 high releases", 0, 8'h0);

    // R10 enable and combined request
    wr(2'd2, 4'b0001);
    pin_in[0] = 1'b0; step(3);
    push("R10 pending", 0, 8'h1);
    step(1);
    push("R10 req up", 1, 8'h1);
    pin_in[0] = 1'b1; step(4);
    push("R10 req down", 1, 8'h0);
    pin_in[1] = 1'b0; step(4);
    push("R12 line1 only", 0, 8'h2);
    push("R10 masked line", 1, 8'h0);
    pin_in[1] = 1'b1; step(3);

    // R3 positive level on line 2 (pin high)
    wr(2'd0, 4'b0100); step(1);
    push("R3 pol flip", 0, 8'h4);
    pin_in[2] = 1'b0; step(3);
    push("R3 low inactive", 0, 8'h0);
    rd_chk("R11 pol", 2'd0, 4'b0100);
    rd_chk("R11 en", 2'd2, 4'b0001);

    // R4 edge negative on line 0
    wr(2'd1, 4'b0001); step(3);
    push("R4 no edge yet", 0, 8'h0);
    pin_in[0] = 1'b0; step(3);
    push("R4 fall sets", 0, 8'h1);
    pin_in[0] = 1'b1; step(3);
    push("R4 held", 0, 8'h1);
    rd_chk("R11 stat", 2'd3, 4'b0001);
    rd_chk("R11 mode", 2'd1, 4'b0001);

    // R6 clear
    wr(2'd3, 4'b0000);
    push("R6 zero keeps", 0, 8'h1);
    wr(2'd3, 4'b0001);
    push("R6 one clears", 0, 8'h0);

    // R5 edge positive on line 1
    wr(2'd0, 4'b0110); step(1);
    push("R5 level pos", 0, 8'h2);
    pin_in[1] = 1'b0; step(3);
    push("R5 low idle", 0, 8'h0);
    wr(2'd1, 4'b0011); step(1);
    push("R5 switch inactive", 0, 8'h0);
    pin_in[1] = 1'b1; step(3);
    push("R5 rise sets", 0, 8'h2);
    pin_in[1] = 1'b0; step(3);
    push("R5 fall keeps", 0, 8'h2);
    wr(2'd3, 4'b0010);
    push("R6 line1 clear", 0, 8'h0);

    // R7 level clear with active condition (line 2 positive)
    pin_in[2] = 1'b1; step(3);
    push("R7 active", 0, 8'h4);
    wr(2'd3, 4'b0100);
    push("R7 clear no effect", 0, 8'h4);
    step(1);
    push("R7 still set", 0, 8'h4);

    // R8 edge and clear in same cycle on line 0
    pin_in[0] = 1'b0; step(3);
    pin_in[0] = 1'b1; step(3);
    push("R8 armed", 0, 8'h5);
    pin_in[0] = 1'b0; step(2);
    wr(2'd3, 4'b0001);
    push("R8 edge wins", 0, 8'h5);
    pin_in[0] = 1'b1; step(3);
    wr(2'd3, 4'b0001);
    push("R8 later clear", 0, 8'h4);

    // R9 level-to-edge switch with active condition on line 3
    pin_in[3] = 1'b0; step(3);
    push("R9 level active", 0, 8'hC);
    wr(2'd1, 4'b1011);
    wr(2'd3, 4'b1000);
    push("R9 spurious kept", 0, 8'hC);
    wr(2'd3, 4'b1000);
    push("R9 second clear", 0, 8'h4);

    step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule